// File: doc/BRIEF.md
# Coherence Message Wire-Class Selector

This block sits where a cache controller or a directory hands coherence traffic to the on-chip network. Each cycle it can take one outgoing message, described by its category, its payload width in bits, a negative-acknowledge flag and up to 64 payload bits. It picks one of three parallel lanes for the message: a 16-bit fast lane, a 64-bit baseline lane or a 64-bit low-power lane. Each lane is a fully pipelined delay line with its own latency. The message is never split across lanes.

At the far end, a receive multiplexer presents each arriving message together with the lane it used and its category. Messages on different lanes can overtake each other. A counter tracks the messages that have been issued but not yet delivered. When traffic is heavy, this counter sends negative acknowledges to the low-power lane instead of the fast lane. Issue stalls only when the chosen lane would deliver in the same cycle as a message already travelling on a slower lane.

Top module: `coh_wire_select`

## Requirements
- R1: Category codes 1 (eviction writeback) and 3 (owner writeback to home) always travel on lane code 2 (low-power), whatever their width or flag.
- R2: Category codes 0 (request) and 2 (probe) carry a full address and always travel on lane code 1 (baseline), never on lane code 0 (fast).
- R3: Category codes 4 (response) and 5 (home reply) without the nack flag use lane code 0 when their width is at most 16 bits (16 included) and lane code 1 when it is wider. Codes 6 and 7 use lane code 1.
- R4: A code 4 or 5 message with the nack flag set uses lane 0 while fewer than CONG_THRESH (default 8) messages are in flight at its issue cycle, and lane 2 when that many or more are in flight. A message is in flight from its issue cycle until its delivery cycle.
- R5: A message accepted in cycle t is presented at the output in cycle t+5 on lane 0, t+10 on lane 1 and t+15 on lane 2.
- R6: The lanes are fully pipelined. A message accepted every cycle on lane 2 never stalls, and every one of them is delivered.
- R7: At most one message is presented per cycle. inReady is low exactly when the lane the current inputs select would deliver in the same cycle as a message already on a slower lane. inReady depends on the inputs even while inValid is low, and lane 2 is never stalled.
- R8: The output carries the lane code, the category and the nack flag of the message. Lane 0 carries only payload bits 15:0, so the upper 48 output bits read zero. Lanes 1 and 2 carry all 64 bits.
- R9: While reset is held, outValid is low. After reset, the in-flight count starts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Message offered |
| inReady | output | 1 | Selected lane can accept this cycle |
| inCat | input | 3 | Message category code |
| inWidth | input | 7 | Payload width in bits |
| inNack | input | 1 | Message is a negative acknowledge |
| inPayload | input | 64 | Message payload |
| outValid | output | 1 | Message delivered this cycle |
| outLane | output | 2 | Lane that carried it (0 fast, 1 baseline, 2 low-power) |
| outCat | output | 3 | Category of the delivered message |
| outNack | output | 1 | Nack flag of the delivered message |
| outPayload | output | 64 | Delivered payload |

## Verification
The steering rule is swept over every category code, over widths of 1, 8, 15, 16, 17 and 64 bits, and over both nack values, with the lanes empty. This sweep separates the category overrides from the width rule and pins down the 16/17-bit boundary. Each delivery's latency, tag and payload truncation identify the lane independently of outLane. Bursts of 7 and 8 back-to-back writebacks followed by a nack probe the congestion threshold on both sides. A baseline message followed by a fast one shows the stall in exactly the colliding cycle and the overtaking order that results.

// File: rtl/cwc_pkg.sv
`timescale 1ns/1ps
package cwc_pkg;
  localparam int NUM_LANES = 3;

  localparam logic [1:0] LANE_FAST   = 2'd0;
  localparam logic [1:0] LANE_BASE   = 2'd1;
  localparam logic [1:0] LANE_LOWPWR = 2'd2;

  localparam logic [2:0] CAT_REQ        = 3'd0;
  localparam logic [2:0] CAT_EVICT      = 3'd1;
  localparam logic [2:0] CAT_PROBE      = 3'd2;
  localparam logic [2:0] CAT_OWNER_WB   = 3'd3;
  localparam logic [2:0] CAT_RESP       = 3'd4;
  localparam logic [2:0] CAT_HOME_REPLY = 3'd5;

  // strobes from control to the lane datapath
  typedef struct packed {
    logic [NUM_LANES-1:0] issue;
  } laneStrobe_t;
endpackage

// File: rtl/cwc_delay_line.sv
`timescale 1ns/1ps
module cwc_delay_line #(
  parameter int DEPTH = 5,
  parameter int DW    = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [DW-1:0]    inData,
  output logic [DEPTH-1:0] tapValid,
  output logic [DW-1:0]    outData
);
  logic [DEPTH-1:0] vld;
  logic [DW-1:0]    dat [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) vld <= '0;
    else       vld <= {vld[DEPTH-2:0], inValid};
  end

  always_ff @(posedge clk) begin
    dat[0] <= inData;
    for (int s = 1; s < DEPTH; s++) dat[s] <= dat[s-1];
  end

  assign tapValid = vld;
  assign outData  = dat[DEPTH-1];
endmodule

// File: rtl/cwc_lane_dp.sv
`timescale 1ns/1ps
module cwc_lane_dp
  import cwc_pkg::*;
#(
  parameter int LAT_FAST   = 5,
  parameter int LAT_BASE   = 10,
  parameter int LAT_LOWPWR = 15,
  parameter int WIDE_W     = 64,
  parameter int NARROW_W   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  laneStrobe_t          strobes,
  input  logic [2:0]           inCat,
  input  logic                 inNack,
  input  logic [WIDE_W-1:0]    inPayload,
  output logic [NUM_LANES-1:0] laneBlocked,
  output logic                 outValid,
  output logic [1:0]           outLane,
  output logic [2:0]           outCat,
  output logic                 outNack,
  output logic [WIDE_W-1:0]    outPayload
);
  localparam int MAXD = LAT_LOWPWR;

  function automatic int latOf(int i);
    case (i)
      0:       return LAT_FAST;
      1:       return LAT_BASE;
      default: return LAT_LOWPWR;
    endcase
  endfunction

  logic [MAXD-1:0]      tapV    [NUM_LANES];
  logic [WIDE_W-1:0]    lanePay [NUM_LANES];
  logic [2:0]           laneCat [NUM_LANES];
  logic                 laneNk  [NUM_LANES];
  logic [NUM_LANES-1:0] laneDone;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    localparam int D = (g == 0) ? LAT_FAST : (g == 1) ? LAT_BASE : LAT_LOWPWR;
    localparam int W = (g == 0) ? NARROW_W : WIDE_W;
    logic [D-1:0] taps;
    logic [W+3:0] raw;
    cwc_delay_line #(.DEPTH(D), .DW(W+4)) u_line (
      .clk(clk), .rstN(rstN), .inValid(strobes.issue[g]),
      .inData({inNack, inCat, inPayload[W-1:0]}),
      .tapValid(taps), .outData(raw)
    );
    assign tapV[g]     = MAXD'(taps);
    assign laneDone[g] = taps[D-1];
    assign laneNk[g]   = raw[W+3];
    assign laneCat[g]  = raw[W+2:W];
    assign lanePay[g]  = WIDE_W'(raw[W-1:0]);
  end

  // a lane is blocked when a slower lane already owns its delivery slot
  always_comb begin
    laneBlocked = '0;
    for (int x = 0; x < NUM_LANES; x++)
      for (int y = 0; y < NUM_LANES; y++)
        if (latOf(y) > latOf(x))
          laneBlocked[x] = laneBlocked[x] | tapV[y][latOf(y)-1-latOf(x)];
  end

  always_comb begin
    outValid   = |laneDone;
    outLane    = LANE_FAST;
    outCat     = '0;
    outNack    = 1'b0;
    outPayload = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (laneDone[i]) begin
        outLane    = 2'(i);
        outCat     = laneCat[i];
        outNack    = laneNk[i];
        outPayload = lanePay[i];
      end
    end
  end

  // R7
  lane_collision_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(laneDone));

  // R7
  issue_when_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.issue & laneBlocked) == '0);
endmodule

// File: rtl/cwc_steer_ctrl.sv
`timescale 1ns/1ps
module cwc_steer_ctrl
  import cwc_pkg::*;
#(
  parameter int NARROW_W    = 16,
  parameter int WIDTH_W     = 7,
  parameter int CONG_THRESH = 8,
  parameter int CNT_W       = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [2:0]           inCat,
  input  logic [WIDTH_W-1:0]   inWidth,
  input  logic                 inNack,
  input  logic [NUM_LANES-1:0] laneBlocked,
  input  logic                 deliver,
  output logic                 inReady,
  output laneStrobe_t          strobes
);
  logic [CNT_W-1:0] inFlight;
  logic             congested;
  logic             isNarrow;
  logic [1:0]       sel;
  logic             fire;

  assign congested = inFlight >= CNT_W'(CONG_THRESH);
  assign isNarrow  = inWidth <= WIDTH_W'(NARROW_W);

  always_comb begin
    case (inCat)
      CAT_EVICT, CAT_OWNER_WB: sel = LANE_LOWPWR;
      CAT_REQ, CAT_PROBE:      sel = LANE_BASE;
      CAT_RESP, CAT_HOME_REPLY: begin
        if (inNack)        sel = congested ? LANE_LOWPWR : LANE_FAST;
        else if (isNarrow) sel = LANE_FAST;
        else               sel = LANE_BASE;
      end
      default:                 sel = LANE_BASE;
    endcase
  end

  assign inReady = !laneBlocked[sel];
  assign fire    = inValid && inReady;

  always_comb begin
    strobes.issue = '0;
    if (fire) strobes.issue[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) inFlight <= '0;
    else       inFlight <= inFlight + CNT_W'(fire) - CNT_W'(deliver);
  end

  // R1
  evict_lowpwr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (inCat == CAT_EVICT || inCat == CAT_OWNER_WB))
      |-> (inReady && strobes.issue[LANE_LOWPWR]));

  // R2
  addr_not_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inCat == CAT_REQ || inCat == CAT_PROBE) |-> !strobes.issue[LANE_FAST]);

  // R6
  issue_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.issue != '0) |-> inValid);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    deliver |-> (inFlight != '0));
endmodule

// File: rtl/coh_wire_select.sv
`timescale 1ns/1ps
module coh_wire_select
  import cwc_pkg::*;
#(
  parameter int LAT_FAST    = 5,
  parameter int LAT_BASE    = 10,
  parameter int LAT_LOWPWR  = 15,
  parameter int WIDE_W      = 64,
  parameter int NARROW_W    = 16,
  parameter int CONG_THRESH = 8,
  localparam int WIDTH_W    = $clog2(WIDE_W + 1),
  localparam int CNT_W      = $clog2(LAT_FAST + LAT_BASE + LAT_LOWPWR + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [2:0]         inCat,
  input  logic [WIDTH_W-1:0] inWidth,
  input  logic               inNack,
  input  logic [WIDE_W-1:0]  inPayload,
  output logic               outValid,
  output logic [1:0]         outLane,
  output logic [2:0]         outCat,
  output logic               outNack,
  output logic [WIDE_W-1:0]  outPayload
);
  laneStrobe_t          strobes;
  logic [NUM_LANES-1:0] laneBlocked;

  cwc_steer_ctrl #(
    .NARROW_W(NARROW_W), .WIDTH_W(WIDTH_W),
    .CONG_THRESH(CONG_THRESH), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCat(inCat),
    .inWidth(inWidth), .inNack(inNack), .laneBlocked(laneBlocked),
    .deliver(outValid), .inReady(inReady), .strobes(strobes)
  );

  cwc_lane_dp #(
    .LAT_FAST(LAT_FAST), .LAT_BASE(LAT_BASE), .LAT_LOWPWR(LAT_LOWPWR),
    .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inCat(inCat),
    .inNack(inNack), .inPayload(inPayload), .laneBlocked(laneBlocked),
    .outValid(outValid), .outLane(outLane), .outCat(outCat),
    .outNack(outNack), .outPayload(outPayload)
  );
endmodule

// File: tb/test_coh_wire_select.sv
`timescale 1ns/1ps
module test_coh_wire_select;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic        inReady;
  logic [2:0]  inCat;
  logic [6:0]  inWidth;
  logic        inNack;
  logic [63:0] inPayload;
  logic        outValid;
  logic [1:0]  outLane;
  logic [2:0]  outCat;
  logic        outNack;
  logic [63:0] outPayload;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  coh_wire_select i_coh_wire_select (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inCat(inCat), .inWidth(inWidth), .inNack(inNack), .inPayload(inPayload),
    .outValid(outValid), .outLane(outLane), .outCat(outCat),
    .outNack(outNack), .outPayload(outPayload)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expLane(int cat, int w, bit nk, bit cong);
    if (cat == 1 || cat == 3) return 2;
    if (cat == 0 || cat == 2 || cat >= 6) return 1;
    if (nk) return cong ? 2 : 0;
    return (w <= 16) ? 0 : 1;
  endfunction

  function automatic int expLat(int lane);
    return (lane == 0) ? 5 : (lane == 1) ? 10 : 15;
  endfunction

  task automatic idle();
    inValid = 0; inCat = 0; inWidth = 7'd64; inNack = 0; inPayload = '0;
  endtask

  task automatic drain();
    repeat (20) @(negedge clk);
  endtask

  // one message on an empty pipeline, checked for lane, latency, tag, payload
  task automatic sendOne(input int cat, input int w, input bit nk, input logic [63:0] pay);
    int lane, n;
    logic [63:0] expPay;
    lane = expLane(cat, w, nk, 1'b0);
    @(negedge clk);
    inValid = 1; inCat = 3'(cat); inWidth = 7'(w); inNack = nk; inPayload = pay;
    #0.1;
    check(inReady == 1'b1, "R7 ready on empty lanes", longint'(inReady), 1);
    @(posedge clk);
    @(negedge clk);
    idle();
    n = 1;
    while (!outValid && n < 40) begin
      @(negedge clk);
      n++;
    end
    expPay = (lane == 0) ? {48'h0, pay[15:0]} : pay;
    if (cat == 1 || cat == 3)      check(outLane == 2'(lane), "R1 lane", longint'(outLane), lane);
    else if (cat == 0 || cat == 2) check(outLane == 2'(lane), "R2 lane", longint'(outLane), lane);
    else if (nk && cat >= 4 && cat <= 5)
                                   check(outLane == 2'(lane), "R4 nack lane", longint'(outLane), lane);
    else                           check(outLane == 2'(lane), "R3 lane", longint'(outLane), lane);
    check(n == expLat(lane), "R5 latency", n, expLat(lane));
    check(outCat == 3'(cat) && outNack == nk, "R8 tag", {outCat, outNack}, {cat[2:0], nk});
    check(outPayload == expPay, "R8 payload", outPayload, expPay);
  endtask

  // burst of writebacks then a nack; congestion decides the nack lane
  task automatic burstNack(input int nWr);
    int expL, k, nackLat, nackLane, wr;
    bit allReady;
    expL = expLane(5, 12, 1'b1, nWr >= 8);
    allReady = 1;
    for (int i = 0; i < nWr; i++) begin
      @(negedge clk);
      inValid = 1; inCat = 3'd1; inWidth = 7'd64; inNack = 0; inPayload = 64'(i);
      #0.1;
      allReady &= inReady;
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1; inCat = 3'd5; inWidth = 7'd12; inNack = 1; inPayload = 64'h0123;
    @(posedge clk);
    check(allReady, "R6 lowpwr never stalls", longint'(allReady), 1);
    nackLat = -1; nackLane = -1; wr = 0;
    for (k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1) idle();
      if (outValid) begin
        if (outCat == 3'd5) begin nackLat = k; nackLane = int'(outLane); end
        else if (outCat == 3'd1) wr++;
      end
    end
    check(nackLane == expL, "R4 congestion lane", nackLane, expL);
    check(nackLat == expLat(expL), "R5 nack latency", nackLat, expLat(expL));
    check(wr == nWr, "R6 all writebacks delivered", wr, nWr);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int widths [6] = '{1, 8, 15, 16, 17, 64};
    int t0, baseAt, fastAt;
    idle();
    rstN = 0;
    repeat (4) @(negedge clk);
    check(outValid == 1'b0, "R9 no output in reset", longint'(outValid), 0);
    rstN = 1;
    // R9: first nack after reset must find zero in flight and take the fast lane
    sendOne(5, 12, 1'b1, 64'hFEED_0000_0000_ABCD);

    // R1 R2 R3 R4 R5 R8 sweep
    for (int c = 0; c < 8; c++)
      for (int wi = 0; wi < 6; wi++)
        for (int nk = 0; nk < 2; nk++)
          sendOne(c, widths[wi], nk[0],
                  {16'hA5C3, 8'(c), 8'(wi), 16'hBEEF, 8'(nk), 8'(c * 16 + wi)});

    drain();
    burstNack(7);
    drain();
    burstNack(8);
    drain();

    // R7 stall: baseline issued at t0, fast one collides at t0+5
    @(negedge clk);
    inValid = 1; inCat = 3'd4; inWidth = 7'd64; inNack = 0; inPayload = 64'hB0B0;
    @(posedge clk);
    @(negedge clk);                 // cycle t0+1
    idle();
    inCat = 3'd4; inWidth = 7'd8;   // selects fast lane, not offered yet
    repeat (3) @(negedge clk);      // t0+4
    #0.1;
    check(inReady == 1'b1, "R7 ready before slot", longint'(inReady), 1);
    @(negedge clk);                 // t0+5
    inValid = 1; inPayload = 64'hF0F0;
    #0.1;
    check(inReady == 1'b0, "R7 stall in colliding cycle", longint'(inReady), 0);
    @(negedge clk);                 // t0+6
    #0.1;
    check(inReady == 1'b1, "R7 ready after slot", longint'(inReady), 1);
    @(posedge clk);
    t0 = 6; baseAt = -1; fastAt = -1;
    for (int k = 7; k <= 20; k++) begin
      @(negedge clk);
      if (k == 7) idle();
      if (outValid && outLane == 2'd1) baseAt = k;
      if (outValid && outLane == 2'd0) fastAt = k;
    end
    check(baseAt == 10, "R7 baseline delivery cycle", baseAt, 10);
    check(fastAt == 11, "R7 fast delivery after stall", fastAt, t0 + 5);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule